// File: doc/BRIEF.md
# Dual Timer Interrupt Controller

Two 16-bit down-counters and a shift-event interrupt source share one byte-wide register window and one level interrupt line. Software loads the counters through latch registers, picks one-shot or free-reloading behaviour for the first timer, and masks each of the three interrupt sources. The interrupt line is high whenever any pending source is also enabled.

The first timer decrements once every `T1_DIV` clocks. The second timer decrements once every `T2_DIV` clocks, a slower rate. Its counter is loaded only when the high byte of its count is written, and it keeps counting through every underflow. The shift-event source takes a one-cycle `sr_event` pulse from a neighbouring serial block. When the port direction register holds 0xFF, the event is flagged at once. Otherwise it is flagged after `SR_DELAY` clocks, and a new event restarts that wait.

Register offsets on `reg_addr`: 0/1 timer-1 count low/high, 2/3 timer-1 latch low/high, 4/5 timer-2 count low/high, 6 mode, 7 flags, 8 enables, 9 port direction, 10/11 timer-2 latch low/high (read only). Flag and enable bits: bit 0 timer 1, bit 1 timer 2, bit 2 shift event.

Top module: `dual_timer_irq`

## Requirements
- R1: `irq` is high exactly when (flags AND enables) has bit 0, 1 or 2 set. It follows a flag or enable change on the same clock edge that changes the register.
- R2: Writing offset 4 replaces only the low byte of the timer-2 latch (readable at offsets 10/11). The high byte of the latch and the running timer-2 count are unchanged.
- R3: Writing offset 5 sets the latch high byte and clears flag bit 1. On the same edge it loads the counter with the full latch value N. The timer then flags an underflow (N+1)·T2_DIV clocks after that write edge.
- R4: Reading offset 4 clears flag bit 1, and `irq` drops on the same edge.
- R5: On every timer-2 underflow, flag bit 1 is set and the counter wraps to 0xFFFF and keeps counting, whatever the mode register holds.
- R6: Writing offset 1 loads timer 1 from {data, latch low}, clears flag bit 0 and arms the timer. When mode bit 0 is 0, only the first underflow after a load sets flag bit 0. When mode bit 0 is 1, every underflow sets it and the counter reloads from the latch.
- R7: After reset, both latches and both counters are 0xFFFF, port direction is 0xFF, and flags, enables, mode and `irq` are 0.
- R8: An `sr_event` pulse while port direction is 0xFF sets flag bit 2 on the same edge.
- R9: An `sr_event` pulse while port direction is not 0xFF sets flag bit 2 exactly SR_DELAY clocks later. A further pulse during the wait restarts the full delay.
- R10: Writing offset 7 clears each flag bit written as 1 and leaves the others alone. A read of offset 7 returns the flags in bits 2..0 and, in bit 7, the OR of (flags AND enables).
- R11: Offsets 2, 3, 6, 8 and 9 read back what was last written to them. For offset 8 only bits 2..0 are stored. Read data appears on `reg_rdata` one clock after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe; reads of offsets 0 and 4 have side effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the clock after `reg_rd` |
| sr_event | input | 1 | Single-cycle shift-event pulse |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that reset is applied before the first access. They also assume that `reg_wr` and `reg_rd` are never high together, and that `sr_event` is a single-cycle pulse. The checks that a flag is cleared after a read or write also rely on a clear winning over an underflow on the same edge, which the design guarantees.

The stimulus changes inputs only on falling edges and makes at most one register access per cycle. Each timer load is timed so that it does not coincide with a pending underflow, and pulses are spaced so that their expected edges can be counted exactly.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int NFLAG = 3;

  localparam int F_T1 = 0;
  localparam int F_T2 = 1;
  localparam int F_SR = 2;
  localparam int MODE_CONT_BIT = 0;

  typedef enum logic [3:0] {
    A_T1_CNT_LO = 4'd0,
    A_T1_CNT_HI = 4'd1,
    A_T1_LAT_LO = 4'd2,
    A_T1_LAT_HI = 4'd3,
    A_T2_CNT_LO = 4'd4,
    A_T2_CNT_HI = 4'd5,
    A_MODE      = 4'd6,
    A_FLAGS     = 4'd7,
    A_ENABLES   = 4'd8,
    A_DIRB      = 4'd9,
    A_T2_LAT_LO = 4'd10,
    A_T2_LAT_HI = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/dti_timer.sv
module dti_timer
  import dti_pkg::*;
#(
  parameter int DIV      = 1,
  parameter bit ONE_SHOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_lo_we,
  input  logic          lat_hi_we,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cont_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] lat_o,
  output logic          evt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lat_q;
  logic          armed_q;
  logic          tick;
  logic          underflow;

  // prescaler: restarts on every load so the first tick is DIV clocks out
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || load_i)                pre_q <= '0;
        else if (pre_q == PW'(DIV - 1))   pre_q <= '0;
        else                              pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(DIV - 1));
    end
  endgenerate

  assign underflow = tick && (cnt_q == '0) && !load_i;

  generate
    if (ONE_SHOT) begin : g_oneshot
      assign evt_o = underflow && (armed_q || cont_i);
    end else begin : g_free
      assign evt_o = underflow;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '1;
    end else begin
      if (lat_lo_we) lat_q[DW-1:0]  <= wdata_i;
      if (lat_hi_we) lat_q[CW-1:DW] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '1;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= {wdata_i, lat_q[DW-1:0]};
      armed_q <= 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_q <= (ONE_SHOT && cont_i) ? lat_q : '1;
        if (!cont_i) armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;

  AST_LAT_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (lat_lo_we && !lat_hi_we) |=> (lat_q[CW-1:DW] == $past(lat_q[CW-1:DW]))); // R2

  AST_LOAD_TAKES_LATCH: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == {$past(wdata_i), $past(lat_q[DW-1:0])})); // R3

  AST_UNDERFLOW_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (underflow && !(ONE_SHOT && cont_i)) |=> (cnt_q == '1)); // R5

  AST_ONESHOT_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (ONE_SHOT && underflow && !cont_i) |=> !armed_q); // R6
endmodule

// File: rtl/dti_sr_delay.sv
module dti_sr_delay #(
  parameter int DELAY = 235
) (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  input  logic bypass_i,
  output logic set_o
);
  localparam int DCW = $clog2(DELAY + 1);

  logic [DCW-1:0] dly_q;
  logic           start;
  logic           expire;

  assign start  = event_i && !bypass_i;
  assign expire = (dly_q == DCW'(1)) && !start;
  assign set_o  = (event_i && bypass_i) || expire;

  always_ff @(posedge clk) begin
    if (rst)              dly_q <= '0;
    else if (start)       dly_q <= DCW'(DELAY);
    else if (dly_q != '0) dly_q <= dly_q - 1'b1;
  end

  AST_SR_RESTART: assert property (@(posedge clk) disable iff (rst)
    start |=> (dly_q == DCW'(DELAY))); // R9

  AST_SR_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dly_q == '0 && !event_i) |-> !set_o); // R9
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dti_pkg::*;
#(
  parameter int T1_DIV   = 1,
  parameter int T2_DIV   = 6,
  parameter int SR_DELAY = 235
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sr_event,
  output logic       irq
);
  logic [DW-1:0]    mode_q, dirb_q, rdata_q, rmux;
  logic [NFLAG-1:0] flag_q, flag_d, ier_q, ier_d, fset, fclr;
  logic             irq_q;
  logic [CW-1:0]    t1_cnt, t1_lat, t2_cnt, t2_lat;
  logic             t1_evt, t2_evt, sr_set;

  logic wr_t1lo, wr_t1hi, wr_l1lo, wr_l1hi, wr_t2lo, wr_t2hi;
  logic wr_mode, wr_flag, wr_ien, wr_dirb, rd_t1lo, rd_t2lo;

  assign wr_t1lo = reg_wr && (reg_addr == A_T1_CNT_LO);
  assign wr_t1hi = reg_wr && (reg_addr == A_T1_CNT_HI);
  assign wr_l1lo = reg_wr && (reg_addr == A_T1_LAT_LO);
  assign wr_l1hi = reg_wr && (reg_addr == A_T1_LAT_HI);
  assign wr_t2lo = reg_wr && (reg_addr == A_T2_CNT_LO);
  assign wr_t2hi = reg_wr && (reg_addr == A_T2_CNT_HI);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_flag = reg_wr && (reg_addr == A_FLAGS);
  assign wr_ien  = reg_wr && (reg_addr == A_ENABLES);
  assign wr_dirb = reg_wr && (reg_addr == A_DIRB);
  assign rd_t1lo = reg_rd && (reg_addr == A_T1_CNT_LO);
  assign rd_t2lo = reg_rd && (reg_addr == A_T2_CNT_LO);

  dti_timer #(.DIV(T1_DIV), .ONE_SHOT(1'b1)) u_t1 (
    .clk(clk), .rst(rst),
    .lat_lo_we(wr_t1lo || wr_l1lo), .lat_hi_we(wr_t1hi || wr_l1hi),
    .load_i(wr_t1hi), .wdata_i(reg_wdata), .cont_i(mode_q[MODE_CONT_BIT]),
    .cnt_o(t1_cnt), .lat_o(t1_lat), .evt_o(t1_evt)
  );

  dti_timer #(.DIV(T2_DIV), .ONE_SHOT(1'b0)) u_t2 (
    .clk(clk), .rst(rst),
    .lat_lo_we(wr_t2lo), .lat_hi_we(wr_t2hi),
    .load_i(wr_t2hi), .wdata_i(reg_wdata), .cont_i(mode_q[MODE_CONT_BIT]),
    .cnt_o(t2_cnt), .lat_o(t2_lat), .evt_o(t2_evt)
  );

  dti_sr_delay #(.DELAY(SR_DELAY)) u_sr (
    .clk(clk), .rst(rst), .event_i(sr_event),
    .bypass_i(dirb_q == 8'hFF), .set_o(sr_set)
  );

  // clears win over a set arriving on the same edge
  always_comb begin
    fset        = '0;
    fset[F_T1]  = t1_evt;
    fset[F_T2]  = t2_evt;
    fset[F_SR]  = sr_set;
    fclr        = wr_flag ? reg_wdata[NFLAG-1:0] : '0;
    fclr[F_T1]  = fclr[F_T1] || rd_t1lo || wr_t1hi;
    fclr[F_T2]  = fclr[F_T2] || rd_t2lo || wr_t2hi;
    flag_d      = (flag_q | fset) & ~fclr;
    ier_d       = wr_ien ? reg_wdata[NFLAG-1:0] : ier_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ier_q  <= '0;
      irq_q  <= 1'b0;
      mode_q <= '0;
      dirb_q <= 8'hFF;
    end else begin
      flag_q <= flag_d;
      ier_q  <= ier_d;
      irq_q  <= |(flag_d & ier_d);
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_dirb) dirb_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_T1_CNT_LO: rmux = t1_cnt[DW-1:0];
      A_T1_CNT_HI: rmux = t1_cnt[CW-1:DW];
      A_T1_LAT_LO: rmux = t1_lat[DW-1:0];
      A_T1_LAT_HI: rmux = t1_lat[CW-1:DW];
      A_T2_CNT_LO: rmux = t2_cnt[DW-1:0];
      A_T2_CNT_HI: rmux = t2_cnt[CW-1:DW];
      A_MODE:      rmux = mode_q;
      A_FLAGS:     rmux = {|(flag_q & ier_q), {(DW-1-NFLAG){1'b0}}, flag_q};
      A_ENABLES:   rmux = {{(DW-NFLAG){1'b0}}, ier_q};
      A_DIRB:      rmux = dirb_q;
      A_T2_LAT_LO: rmux = t2_lat[DW-1:0];
      A_T2_LAT_HI: rmux = t2_lat[CW-1:DW];
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_rd) rdata_q <= rmux;
    else             rdata_q <= '0;
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_q & ier_q)); // R1

  AST_T2_HI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_t2hi |=> !flag_q[F_T2]); // R3

  AST_T2_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_t2lo |=> !flag_q[F_T2]); // R4

  AST_SR_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (sr_event && dirb_q == 8'hFF && !(wr_flag && reg_wdata[F_SR])) |=> flag_q[F_SR]); // R8

  AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && !reg_wdata[F_SR] && flag_q[F_SR]) |=> flag_q[F_SR]); // R10
endmodule

// File: tb/sim_dual_timer_irq.sv
`timescale 1ns/1ps
module sim_dual_timer_irq;
  localparam int T1D = 1;
  localparam int T2D = 6;
  localparam int SRD = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sr_event = 1'b0;
  logic       irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dual_timer_irq #(.T1_DIV(T1D), .T2_DIV(T2D), .SR_DELAY(SRD)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sr_event(sr_event), .irq(irq)
  );

  // {offset, write data, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'd2, 8'h5A, 8'h5A},
    {8'd3, 8'hA5, 8'hA5},
    {8'd6, 8'h01, 8'h01},
    {8'd8, 8'hFF, 8'h07},
    {8'd9, 8'h3C, 8'h3C},
    {8'd9, 8'hFF, 8'hFF},
    {8'd6, 8'h00, 8'h00},
    {8'd8, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse();
    sr_event = 1'b1;
    @(negedge clk);
    sr_event = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R7 reset state
    check("R7 irq", {7'b0, irq}, 8'h00);
    rd(4'd9, d);  check("R7 dirb", d, 8'hFF);
    rd(4'd2, d);  check("R7 t1 latch lo", d, 8'hFF);
    rd(4'd3, d);  check("R7 t1 latch hi", d, 8'hFF);
    rd(4'd10, d); check("R7 t2 latch lo", d, 8'hFF);
    rd(4'd11, d); check("R7 t2 latch hi", d, 8'hFF);
    rd(4'd1, d);  check("R7 t1 count hi", d, 8'hFF);
    rd(4'd7, d);  check("R7 flags", d, 8'h00);

    // R11 register readback table
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], d);
      check("R11 readback", d, VEC[i][7:0]);
    end

    // R2 low write touches only latch low, counter keeps running
    wr(4'd4, 8'h03);
    rd(4'd10, d); check("R2 t2 latch lo", d, 8'h03);
    rd(4'd11, d); check("R2 t2 latch hi kept", d, 8'hFF);
    rd(4'd5, d);  check("R2 t2 count untouched", d, 8'hFF);

    // R3 high write loads 0x0003 -> underflow at edge 24
    wr(4'd8, 8'h02);
    wr(4'd5, 8'h00);
    idle(23);
    check("R3 before underflow", {7'b0, irq}, 8'h00);
    idle(1);
    check("R3 underflow irq R1", {7'b0, irq}, 8'h01);

    // R4 read low clears T2 flag at once
    rd(4'd4, d);
    check("R4 irq after read", {7'b0, irq}, 8'h00);
    // R5 counter wrapped and still counting
    rd(4'd5, d); check("R5 wrapped high", d, 8'hFF);

    // R5/R3 latch 0 -> flag each load; high write clears
    wr(4'd4, 8'h00);
    wr(4'd5, 8'h00);
    idle(6);
    check("R5 underflow flag", {7'b0, irq}, 8'h01);
    wr(4'd5, 8'h00);
    check("R3 high write clears", {7'b0, irq}, 8'h00);
    idle(8);
    wr(4'd7, 8'h07);
    rd(4'd7, d); check("R10 all cleared", d, 8'h00);

    // R8 immediate shift event
    wr(4'd8, 8'h04);
    pulse();
    check("R8 immediate", {7'b0, irq}, 8'h01);
    wr(4'd7, 8'h04);
    check("R10 w1c sr", {7'b0, irq}, 8'h00);

    // R9 delayed event
    wr(4'd9, 8'h00);
    pulse();
    idle(SRD - 1);
    check("R9 before delay", {7'b0, irq}, 8'h00);
    idle(1);
    check("R9 after delay", {7'b0, irq}, 8'h01);
    wr(4'd7, 8'h04);

    // R9 restart
    pulse();
    idle(9);
    pulse();
    idle(SRD - 1);
    check("R9 restart not yet", {7'b0, irq}, 8'h00);
    idle(1);
    check("R9 restart fires", {7'b0, irq}, 8'h01);

    // R10 / R1 summary bit and gating
    rd(4'd7, d); check("R10 summary set", d, 8'h84);
    wr(4'd8, 8'h00);
    check("R1 masked irq", {7'b0, irq}, 8'h00);
    rd(4'd7, d); check("R10 summary masked", d, 8'h04);
    wr(4'd7, 8'h03);
    rd(4'd7, d); check("R10 zero bits ignored", d, 8'h04);
    wr(4'd7, 8'h04);
    rd(4'd7, d); check("R10 cleared", d, 8'h00);

    // R6 continuous timer 1, latch 5 -> period 6
    wr(4'd8, 8'h01);
    wr(4'd6, 8'h01);
    wr(4'd2, 8'h05);
    wr(4'd1, 8'h00);
    idle(5);
    check("R6 cont before", {7'b0, irq}, 8'h00);
    idle(1);
    check("R6 cont first", {7'b0, irq}, 8'h01);
    wr(4'd7, 8'h01);
    check("R6 cont cleared", {7'b0, irq}, 8'h00);
    idle(4);
    check("R6 cont gap", {7'b0, irq}, 8'h00);
    idle(1);
    check("R6 cont second", {7'b0, irq}, 8'h01);

    // R6 one-shot
    wr(4'd6, 8'h00);
    wr(4'd2, 8'h05);
    wr(4'd1, 8'h00);
    check("R6 load clears", {7'b0, irq}, 8'h00);
    idle(5);
    check("R6 oneshot before", {7'b0, irq}, 8'h00);
    idle(1);
    check("R6 oneshot fires", {7'b0, irq}, 8'h01);
    wr(4'd7, 8'h01);
    idle(65540);
    check("R6 oneshot no repeat", {7'b0, irq}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule